// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block resolves a 4 KiB page-frame number into one of eight DRAM chip-select rows. Software or boot logic loads eight cumulative row boundaries, a per-row device-width word and a controller mode word through a plain register write port. Every cycle the block compares the presented page against the boundaries and, one clock later, reports which row owns the page, where that row starts and ends, how many pages each channel carries, whether the row is built from x4 or x8 devices, and which ECC scheme protects it.

Boundaries are cumulative: each register holds the running total of memory up to and including its row, so the last populated register equals the installed capacity. A row whose total does not grow past the previous one holds no memory and is passed over. Boundary units are 32 MiB or 64 MiB, chosen in the mode word. The ECC scheme depends on both the channel count and the row's device width.

Top module: `rdb_decoder`

## Requirements
- R1: After reset every output is 0 and every register reads back as 0.
- R2: Register addresses 0 to 7 hold the row boundaries (bits 7:0 of the written data, read back zero-extended), address 8 holds the device-width word and address 9 the mode word; a read returns the stored value combinationally.
- R3: A boundary value B converts to pages as B shifted left by 13 when mode bit 18 is 0 (32 MiB units) and by 14 when it is 1 (64 MiB units); mode bit 19 has no effect on the conversion.
- R4: Row i hits when its previous cumulative boundary (0 for row 0) is at or below the page and its own boundary is above it; the block then reports hit_o=1, row_o=i, first_page_o equal to the previous boundary and last_page_o equal to its own boundary minus one.
- R5: A row whose boundary equals the previous row's boundary never hits; the page falls to the next populated row.
- R6: A page at or above every boundary gives hit_o=0 and all other outputs 0.
- R7: x4_o for the selected row is bit 4*i+3 of the device-width word (1 means x4, 0 means x8).
- R8: ecc_mode_o is 0 (none) when mode bits 21:20 are both 0; otherwise 2 (four-bit symbol correct, four-bit symbol detect) when mode bit 22 is 1 (two channels) and the row is x4, and 1 (single-error correct, double-error detect) in every other case; value 3 never appears.
- R9: chan_pages_o is the row size in pages with one channel and half of it with two channels.
- R10: Outputs reflect page_i and the register contents at the preceding rising clock edge (one cycle of latency).
- R11: When boundaries decrease so that row ranges overlap, the lowest-numbered matching row wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Register read data |
| page_i | input | 22 | Page-frame number to decode |
| hit_o | output | 1 | Page lies in a populated row |
| row_o | output | 3 | Selected row index |
| first_page_o | output | 22 | First page of the selected row |
| last_page_o | output | 22 | Last page of the selected row |
| x4_o | output | 1 | Selected row uses x4 devices |
| ecc_mode_o | output | 2 | ECC scheme: 0 none, 1 single-error correct, 2 four-bit symbol correct |
| chan_pages_o | output | 22 | Pages of the selected row held by each channel |

## Verification
The awkward cases are the ones a sane memory population never produces: runs of empty rows between populated ones and boundaries that shrink from one row to the next, which make row ranges overlap or vanish. The stimulus reaches them by loading repeated and decreasing boundary values through the write port and then probing the pages on either side of each edge, including the last page of one row and the first page of the next. The ECC and channel-split outcomes are reached by rewriting only the mode word between otherwise identical probes.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  typedef enum logic [1:0] {
    ECC_NONE   = 2'd0,
    ECC_SECDED = 2'd1,
    ECC_SYM4   = 2'd2
  } ecc_mode_e;

  localparam int MODE_DUAL_BIT = 22;
  localparam int MODE_ECC_HI   = 21;
  localparam int MODE_ECC_LO   = 20;
  localparam int MODE_GRAN_BIT = 18;
  // 32 MiB unit expressed in 4 KiB pages: 25 - 12
  localparam int PAGE_SHIFT_BASE = 13;
endpackage

// File: rtl/rdb_regfile.sv
module rdb_regfile #(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int REG_W    = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [REG_W-1:0]               wr_data_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  output logic [REG_W-1:0]               rd_data_o,
  output logic [NUM_ROWS-1:0][BND_W-1:0] bnd_o,
  output logic [REG_W-1:0]               attr_o,
  output logic [REG_W-1:0]               mode_o
);
  localparam logic [ADDR_W-1:0] ATTR_ADDR = ADDR_W'(NUM_ROWS);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_ROWS + 1);

  logic [NUM_ROWS-1:0][BND_W-1:0] bnd_q;
  logic [REG_W-1:0]               attr_q, mode_q;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_bnd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      bnd_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))      bnd_q[g] <= wr_data_i[BND_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q <= '0;
      mode_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ATTR_ADDR) attr_q <= wr_data_i;
      if (wr_addr_i == MODE_ADDR) mode_q <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_ROWS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = REG_W'(bnd_q[i]);
    if (rd_addr_i == ATTR_ADDR) rd_data_o = attr_q;
    if (rd_addr_i == MODE_ADDR) rd_data_o = mode_q;
  end

  assign bnd_o  = bnd_q;
  assign attr_o = attr_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/rdb_row_lookup.sv
module rdb_row_lookup
  import rdb_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int REG_W    = 32,
  parameter int PAGE_W   = 22,
  parameter int ROW_W    = 3
) (
  input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd_i,
  input  logic [REG_W-1:0]               attr_i,
  input  logic [REG_W-1:0]               mode_i,
  input  logic [PAGE_W-1:0]              page_i,
  output logic                           hit_o,
  output logic [ROW_W-1:0]               row_o,
  output logic [PAGE_W-1:0]              first_o,
  output logic [PAGE_W-1:0]              last_o,
  output logic                           x4_o,
  output ecc_mode_e                      ecc_o,
  output logic [PAGE_W-1:0]              chan_pages_o
);
  logic [NUM_ROWS-1:0][PAGE_W-1:0] cum_pg, prev_pg;
  logic [NUM_ROWS-1:0]             match;
  logic [$clog2(PAGE_SHIFT_BASE+2)-1:0] shift;
  logic                            dual, ecc_on;
  logic [PAGE_W-1:0]               size;

  assign shift  = PAGE_SHIFT_BASE + mode_i[MODE_GRAN_BIT];
  assign dual   = mode_i[MODE_DUAL_BIT];
  assign ecc_on = |mode_i[MODE_ECC_HI:MODE_ECC_LO];

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    assign cum_pg[g] = PAGE_W'(bnd_i[g]) << shift;
    if (g == 0) begin : g_first
      assign prev_pg[g] = '0;
    end else begin : g_rest
      assign prev_pg[g] = cum_pg[g-1];
    end
    // empty or inverted ranges can never satisfy both compares
    assign match[g] = (page_i >= prev_pg[g]) && (page_i < cum_pg[g]);
  end

  always_comb begin
    hit_o   = 1'b0;
    row_o   = '0;
    first_o = '0;
    last_o  = '0;
    x4_o    = 1'b0;
    size    = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o   = 1'b1;
        row_o   = ROW_W'(i);
        first_o = prev_pg[i];
        last_o  = cum_pg[i] - 1'b1;
        x4_o    = attr_i[4*i+3];
        size    = cum_pg[i] - prev_pg[i];
      end
    end
  end

  always_comb begin
    if (!hit_o || !ecc_on) ecc_o = ECC_NONE;
    else if (dual && x4_o) ecc_o = ECC_SYM4;
    else                   ecc_o = ECC_SECDED;
  end

  assign chan_pages_o = dual ? (size >> 1) : size;
endmodule

// File: rtl/rdb_decoder.sv
module rdb_decoder
  import rdb_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int BND_W    = 8,
  parameter int REG_W    = 32,
  parameter int PAGE_W   = 22,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int ADDR_W  = $clog2(NUM_ROWS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [PAGE_W-1:0] first_page_o,
  output logic [PAGE_W-1:0] last_page_o,
  output logic              x4_o,
  output logic [1:0]        ecc_mode_o,
  output logic [PAGE_W-1:0] chan_pages_o
);
  logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
  logic [REG_W-1:0]               attr, mode;
  logic                           hit_d, x4_d;
  logic [ROW_W-1:0]               row_d;
  logic [PAGE_W-1:0]              first_d, last_d, chan_d;
  ecc_mode_e                      ecc_d;

  rdb_regfile #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .bnd_o     (bnd),
    .attr_o    (attr),
    .mode_o    (mode)
  );

  rdb_row_lookup #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .REG_W(REG_W),
    .PAGE_W(PAGE_W), .ROW_W(ROW_W)
  ) u_lookup (
    .bnd_i        (bnd),
    .attr_i       (attr),
    .mode_i       (mode),
    .page_i       (page_i),
    .hit_o        (hit_d),
    .row_o        (row_d),
    .first_o      (first_d),
    .last_o       (last_d),
    .x4_o         (x4_d),
    .ecc_o        (ecc_d),
    .chan_pages_o (chan_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o        <= 1'b0;
      row_o        <= '0;
      first_page_o <= '0;
      last_page_o  <= '0;
      x4_o         <= 1'b0;
      ecc_mode_o   <= ECC_NONE;
      chan_pages_o <= '0;
    end else begin
      hit_o        <= hit_d;
      row_o        <= row_d;
      first_page_o <= first_d;
      last_page_o  <= last_d;
      x4_o         <= x4_d;
      ecc_mode_o   <= ecc_d;
      chan_pages_o <= chan_d;
    end
  end
endmodule

// File: rtl/rdb_decoder_chk.sv
module rdb_decoder_chk #(
  parameter int PAGE_W = 22,
  parameter int ROW_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PAGE_W-1:0] page_i,
  input logic              hit_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [PAGE_W-1:0] first_page_o,
  input logic [PAGE_W-1:0] last_page_o,
  input logic              x4_o,
  input logic [1:0]        ecc_mode_o,
  input logic [PAGE_W-1:0] chan_pages_o
);
  a_r6_miss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (row_o == '0 && first_page_o == '0 && last_page_o == '0 &&
                !x4_o && ecc_mode_o == 2'd0 && chan_pages_o == '0));

  a_r4_page_in_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($past(page_i) >= first_page_o && $past(page_i) <= last_page_o));

  a_r8_sym4_needs_x4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_mode_o == 2'd2 |-> (x4_o && hit_o));

  a_r8_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_mode_o != 2'd3);

  a_r9_chan_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (chan_pages_o != '0 && chan_pages_o <= last_page_o - first_page_o + 1'b1));
endmodule

bind rdb_decoder rdb_decoder_chk #(.PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .page_i       (page_i),
  .hit_o        (hit_o),
  .row_o        (row_o),
  .first_page_o (first_page_o),
  .last_page_o  (last_page_o),
  .x4_o         (x4_o),
  .ecc_mode_o   (ecc_mode_o),
  .chan_pages_o (chan_pages_o)
);

// File: tb/rdb_decoder_tb.sv
module rdb_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 22;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [3:0]    wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic [3:0]    rd_addr_i = '0;
  logic [31:0]   rd_data_o;
  logic [PW-1:0] page_i = '0;
  logic          hit_o;
  logic [2:0]    row_o;
  logic [PW-1:0] first_page_o, last_page_o, chan_pages_o;
  logic          x4_o;
  logic [1:0]    ecc_mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic          hit;
    logic [2:0]    row;
    logic [PW-1:0] first;
    logic [PW-1:0] last;
    logic          x4;
    logic [1:0]    ecc;
    logic [PW-1:0] chan;
    string         tag;
  } exp_t;

  exp_t q[$];
  logic [7:0]  sh_bnd[8];
  logic [31:0] sh_attr = '0;
  logic [31:0] sh_mode = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rdb_decoder u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .page_i(page_i), .hit_o(hit_o), .row_o(row_o), .first_page_o(first_page_o),
    .last_page_o(last_page_o), .x4_o(x4_o), .ecc_mode_o(ecc_mode_o),
    .chan_pages_o(chan_pages_o)
  );

  function automatic exp_t model(input logic [PW-1:0] pg, input string tag);
    exp_t e;
    longint prev = 0;
    longint cum;
    int sh = 13 + int'(sh_mode[18]);
    e.hit = 0; e.row = 0; e.first = 0; e.last = 0; e.x4 = 0; e.ecc = 0; e.chan = 0;
    e.tag = tag;
    for (int i = 0; i < 8; i++) begin
      cum = longint'(sh_bnd[i]) << sh;
      if (!e.hit && longint'(pg) >= prev && longint'(pg) < cum) begin
        e.hit   = 1;
        e.row   = 3'(i);
        e.first = PW'(prev);
        e.last  = PW'(cum - 1);
        e.x4    = sh_attr[4*i+3];
        if (sh_mode[21:20] == 2'b00)   e.ecc = 2'd0;
        else if (sh_mode[22] && e.x4)  e.ecc = 2'd2;
        else                           e.ecc = 2'd1;
        e.chan  = sh_mode[22] ? PW'((cum - prev) >> 1) : PW'(cum - prev);
      end
      prev = cum;
    end
    return e;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a < 8)       sh_bnd[a] = d[7:0];
    else if (a == 8) sh_attr = d;
    else if (a == 9) sh_mode = d;
  endtask

  task automatic lookup(input logic [PW-1:0] pg, input string tag);
    @(negedge clk_i);
    page_i = pg;
    q.push_back(model(pg, tag));
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    rd_addr_i = a;
    #1;
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d act=%h exp=%h", tag, a, rd_data_o, exp);
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk_i);
  endtask

  // monitor: pops one expected item per clock after the output register updates
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({hit_o, row_o, first_page_o, last_page_o, x4_o, ecc_mode_o, chan_pages_o} !==
          {e.hit, e.row, e.first, e.last, e.x4, e.ecc, e.chan}) begin
        errors++;
        $display("FAIL %s act hit=%b row=%0d first=%h last=%h x4=%b ecc=%0d chan=%h exp hit=%b row=%0d first=%h last=%h x4=%b ecc=%0d chan=%h",
                 e.tag, hit_o, row_o, first_page_o, last_page_o, x4_o, ecc_mode_o, chan_pages_o,
                 e.hit, e.row, e.first, e.last, e.x4, e.ecc, e.chan);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) sh_bnd[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    @(negedge clk_i);
    checks++;
    if ({hit_o, row_o, first_page_o, last_page_o, x4_o, ecc_mode_o, chan_pages_o} !== '0) begin
      errors++;
      $display("FAIL R1 outputs after reset act hit=%b row=%0d exp all zero", hit_o, row_o);
    end
    chk_rd(4'd3, 32'h0, "R1");
    chk_rd(4'd9, 32'h0, "R1");

    // R2: register map and zero-extended boundary readback
    wr(4'd0, 32'h0000_01F2);
    chk_rd(4'd0, 32'h0000_00F2, "R2");
    wr(4'd8, 32'h0800_0800);
    chk_rd(4'd8, 32'h0800_0800, "R2");
    wr(4'd9, 32'h0010_0000);
    chk_rd(4'd9, 32'h0010_0000, "R2");

    // populated rows 0,2,5,6; rows 1,3,4,7 empty; x4 on rows 2 and 6
    wr(4'd0, 32'd2);  wr(4'd1, 32'd2);  wr(4'd2, 32'd5);  wr(4'd3, 32'd5);
    wr(4'd4, 32'd5);  wr(4'd5, 32'd9);  wr(4'd6, 32'd12); wr(4'd7, 32'd12);
    chk_rd(4'd6, 32'd12, "R2");

    // 32 MiB units, single channel, ECC on
    lookup(22'd0,             "R4 row0 first page");
    lookup(22'd16383,         "R4 R3 row0 last page");
    lookup(22'd16384,         "R5 empty row1 skipped");
    lookup(22'd40960,         "R5 empty rows3-4 skipped");
    lookup(22'd90117,         "R7 R8 row6 x4 single-channel secded");
    lookup(22'd98303,         "R4 last page of memory");
    lookup(22'd98304,         "R6 first page past end");
    lookup(22'h3F_FFFF,       "R6 max page");
    drain();

    // mode bit 19 alone must not change the unit
    wr(4'd9, 32'h0018_0000);
    lookup(22'd16384,         "R3 bit19 ignored");
    lookup(22'd98304,         "R3 R6 bit19 ignored miss");
    drain();

    // 64 MiB units, dual channel, ECC on
    wr(4'd9, 32'h0054_0000);
    lookup(22'd49152,         "R3 R8 R9 row2 dual x4 sym4");
    lookup(22'd100,           "R8 R9 row0 dual x8 secded");
    lookup(22'd196607,        "R3 row6 last page 64MiB");
    lookup(22'd196608,        "R6 miss 64MiB");
    drain();

    // ECC off, dual channel
    wr(4'd9, 32'h0044_0000);
    lookup(22'd49152,         "R8 ecc off none");
    drain();

    // R10: register change seen on the next lookup, back-to-back pages
    wr(4'd7, 32'd20);
    lookup(22'd200000,        "R10 grown row7 hit");
    lookup(22'd0,             "R10 back-to-back row0");
    lookup(22'd327679,        "R10 row7 last page");
    drain();

    // R11: shrinking boundaries, 32 MiB units
    wr(4'd9, 32'h0010_0000);
    wr(4'd0, 32'd10); wr(4'd1, 32'd5); wr(4'd2, 32'd20);
    lookup(22'd57344,         "R11 overlap lowest row wins");
    lookup(22'd98304,         "R11 row2 above row0");
    lookup(22'd40960,         "R11 inverted row1 never hits");
    drain();

    // R7: width bit taken from 4*i+3 only
    wr(4'd8, 32'h0000_0007);
    lookup(22'd0,             "R7 low bits do not set x4");
    wr(4'd8, 32'h0000_0008);
    lookup(22'd0,             "R7 bit3 sets row0 x4");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule